// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupt Controller

This block gathers sixteen interrupt channels into a single request line. Each channel has four bits that software can reach over a small byte-wide register bus. The enable bit decides whether an event is latched at all. The pending bit records a latched event. The mask bit gates whether a pending event raises the request. The in-service bit marks a channel whose handler is still running.

A one-clock pulse on a channel's event input sets its pending bit, provided the channel is enabled. The highest-priority pending, unmasked and unblocked channel drives the request output.

When the processor acknowledges, the block answers with an 8-bit vector. The upper nibble of that vector comes from a software-written base and the lower nibble is the winning channel number. Several controllers can share one acknowledge strobe. Priority flows between them through an active-low chain input and output: a controller that has nothing pending hands priority down the chain, and one that answers holds its chain output inactive.

Top module: `vic_top`

## Requirements
- R1: Register offsets on `bus_addr` are: 0/1 enable, 2/3 pending, 4/5 in-service, 6/7 mask, 8 vector. Even offsets hold channels 15..8 and odd offsets hold channels 7..0, with bit n of each byte mapping to the n-th channel of its half. At offset 8, bits 7:4 are the vector base and bit 3 is the in-service mode; the other bits read as 0. Enable, mask and vector read back as written.
- R2: An event pulse on an enabled channel sets its pending bit. An event on a disabled channel leaves the pending bit at 0.
- R3: Writing a 0 to a pending bit clears it. Writing a 1 leaves it unchanged.
- R4: Clearing an enable bit clears that channel's pending bit in the same write, and leaves its in-service bit unchanged.
- R5: With its mask bit at 0, a channel still latches pending but does not assert `irq_o`. Setting the mask bit back to 1 lets the existing pending bit request again.
- R6: Channel 15 has the highest priority and channel 0 the lowest. The returned vector is {base, channel number}.
- R7: An acknowledge is honoured when `iack_n` and `chain_in_n` are both low and a request is active. One cycle later, `vec_o` holds the vector, `ack_done_o` pulses for one cycle, the winner's pending bit is clear and `chain_out_n` stays high. If `chain_in_n` is high, nothing happens.
- R8: If no request is active when `iack_n` and `chain_in_n` are low, `chain_out_n` goes low on the next cycle. It returns high on the cycle after `iack_n` rises, and `ack_done_o` stays low throughout.
- R9: With the mode bit at 1, an acknowledge sets the winner's in-service bit. A set in-service bit blocks requests from its own channel and all lower channels. Writing 0 to the in-service bit clears it, and writing 1 has no effect.
- R10: With the mode bit at 0, in-service bits are never set.
- R11: After reset, all registers read 0, `irq_o` and `ack_done_o` are low, `vec_o` is 0 and `chain_out_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | One-clock event pulses, bit n for channel n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| iack_n | input | 1 | Acknowledge strobe, active low |
| chain_in_n | input | 1 | Priority from the device above, active low |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector of the last honoured acknowledge |
| ack_done_o | output | 1 | One-cycle acknowledge-complete pulse |
| chain_out_n | output | 1 | Priority to the device below, active low |

## Verification
The bench builds the block with the package defaults: sixteen channels split into two byte halves, and a 4-bit vector base. These values bring within reach channels at both ends of the priority order, writes to both halves of every register, and vectors whose channel nibble spans the whole range. A queue of expected vectors is compared against every completion pulse. The sequences also cover the case where the chain input is held off and the case where nothing is pending, and they exercise in-service blocking in both modes.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NUM_CH  = 16;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int HALF    = NUM_CH / 2;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int BASE_W  = DATA_W - CH_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_EN_HI = 4'd0, SEL_EN_LO = 4'd1,
        SEL_PD_HI = 4'd2, SEL_PD_LO = 4'd3,
        SEL_IS_HI = 4'd4, SEL_IS_LO = 4'd5,
        SEL_MK_HI = 4'd6, SEL_MK_LO = 4'd7,
        SEL_VEC   = 4'd8
    } reg_sel_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              svc_mode;
    } vec_cfg_t;

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] pend;
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] isr;
    } chan_state_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
    } grant_t;

    // Per-channel write strobe for one byte half of a register pair.
    function automatic logic [NUM_CH-1:0] lane_strobe(input logic we, input logic hi);
        return hi ? {{HALF{we}}, {HALF{1'b0}}} : {{HALF{1'b0}}, {HALF{we}}};
    endfunction
endpackage

// File: rtl/vic_bank.sv
module vic_bank
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt,
    input  logic [NUM_CH-1:0] en_we,
    input  logic [NUM_CH-1:0] pd_we,
    input  logic [NUM_CH-1:0] is_we,
    input  logic [NUM_CH-1:0] mk_we,
    input  logic [NUM_CH-1:0] lane_d,
    input  grant_t            take,
    input  logic              svc_mode,
    output chan_state_t       st
);
    logic [NUM_CH-1:0] en_q, pend_q, mask_q, isr_q;
    logic [NUM_CH-1:0] en_n, pend_n, mask_n, isr_n, hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c]    = take.valid && (take.ch == CH_W'(c));
        assign en_n[c]   = en_we[c] ? lane_d[c] : en_q[c];
        assign mask_n[c] = mk_we[c] ? lane_d[c] : mask_q[c];
        // event wins over a clear in the same cycle; enable gates everything
        assign pend_n[c] = en_n[c] &
                           ((pend_q[c] & ~(pd_we[c] & ~lane_d[c]) & ~hit[c]) | evt[c]);
        assign isr_n[c]  = (isr_q[c] & ~(is_we[c] & ~lane_d[c])) | (hit[c] & svc_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            mask_q <= '0;
            isr_q  <= '0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
            mask_q <= mask_n;
            isr_q  <= isr_n;
        end
    end

    assign st = '{en: en_q, pend: pend_q, mask: mask_q, isr: isr_q};
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  chan_state_t     st,
    output logic            req,
    output logic [CH_W-1:0] win
);
    logic [NUM_CH-1:0] elig;

    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            blocked = blocked | st.isr[c];
            elig[c] = st.pend[c] & st.mask[c] & ~blocked;
        end
    end

    always_comb begin
        win = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (elig[c]) win = CH_W'(c);
        end
    end

    assign req = |elig;
endmodule

// File: rtl/vic_ack.sv
module vic_ack
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iack_n,
    input  logic              chain_in_n,
    input  logic              req,
    input  logic [CH_W-1:0]   win,
    input  logic [BASE_W-1:0] base,
    output grant_t            take,
    output logic [DATA_W-1:0] vec_o,
    output logic              done_o,
    output logic              chain_out_n
);
    logic served_q, passed_q, open;

    assign open       = ~iack_n & ~chain_in_n & ~served_q & ~passed_q;
    assign take.valid = open & req;
    assign take.ch    = win;

    always_ff @(posedge clk) begin
        if (rst) begin
            served_q <= 1'b0;
            passed_q <= 1'b0;
            vec_o    <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= take.valid;
            if (take.valid) begin
                vec_o    <= {base, win};
                served_q <= 1'b1;
            end
            if (open && !req) passed_q <= 1'b1;
            if (iack_n) begin
                served_q <= 1'b0;
                passed_q <= 1'b0;
            end
        end
    end

    assign chain_out_n = ~passed_q;
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              iack_n,
    input  logic              chain_in_n,
    output logic              irq_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              ack_done_o,
    output logic              chain_out_n
);
    reg_sel_e          sel;
    vec_cfg_t          vcfg_q;
    chan_state_t       st;
    grant_t            take;
    logic              req;
    logic [CH_W-1:0]   win;
    logic [NUM_CH-1:0] en_we, pd_we, is_we, mk_we, lane_d;

    assign sel    = reg_sel_e'(bus_addr);
    assign lane_d = {2{bus_wdata}};
    assign en_we  = lane_strobe(bus_wr && (sel == SEL_EN_HI || sel == SEL_EN_LO), sel == SEL_EN_HI);
    assign pd_we  = lane_strobe(bus_wr && (sel == SEL_PD_HI || sel == SEL_PD_LO), sel == SEL_PD_HI);
    assign is_we  = lane_strobe(bus_wr && (sel == SEL_IS_HI || sel == SEL_IS_LO), sel == SEL_IS_HI);
    assign mk_we  = lane_strobe(bus_wr && (sel == SEL_MK_HI || sel == SEL_MK_LO), sel == SEL_MK_HI);

    always_ff @(posedge clk) begin
        if (rst) vcfg_q <= '0;
        else if (bus_wr && sel == SEL_VEC)
            vcfg_q <= '{base: bus_wdata[DATA_W-1:CH_W], svc_mode: bus_wdata[CH_W-1]};
    end

    vic_bank u_bank (
        .clk(clk), .rst(rst), .evt(evt_i),
        .en_we(en_we), .pd_we(pd_we), .is_we(is_we), .mk_we(mk_we),
        .lane_d(lane_d), .take(take), .svc_mode(vcfg_q.svc_mode), .st(st)
    );

    vic_prio u_prio (.st(st), .req(req), .win(win));

    vic_ack u_ack (
        .clk(clk), .rst(rst), .iack_n(iack_n), .chain_in_n(chain_in_n),
        .req(req), .win(win), .base(vcfg_q.base), .take(take),
        .vec_o(vec_o), .done_o(ack_done_o), .chain_out_n(chain_out_n)
    );

    assign irq_o = req;

    always_comb begin
        case (sel)
            SEL_EN_HI: bus_rdata = st.en[NUM_CH-1:HALF];
            SEL_EN_LO: bus_rdata = st.en[HALF-1:0];
            SEL_PD_HI: bus_rdata = st.pend[NUM_CH-1:HALF];
            SEL_PD_LO: bus_rdata = st.pend[HALF-1:0];
            SEL_IS_HI: bus_rdata = st.isr[NUM_CH-1:HALF];
            SEL_IS_LO: bus_rdata = st.isr[HALF-1:0];
            SEL_MK_HI: bus_rdata = st.mask[NUM_CH-1:HALF];
            SEL_MK_LO: bus_rdata = st.mask[HALF-1:0];
            SEL_VEC:   bus_rdata = {vcfg_q.base, vcfg_q.svc_mode, {(CH_W-1){1'b0}}};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input chan_state_t       st,
    input vec_cfg_t          vcfg,
    input logic              irq,
    input logic              done,
    input logic [DATA_W-1:0] vec,
    input logic              chain_out_n
);
    assert_pend_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
        (st.pend & ~st.en) == '0);

    assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(st.pend & st.mask));

    assert_ack_holds_chain_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> chain_out_n);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_vec_base_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> vec[DATA_W-1:CH_W] == $past(vcfg.base));

    assert_isr_mode_R10: assert property (@(posedge clk) disable iff (rst)
        |(st.isr & ~$past(st.isr)) |-> $past(vcfg.svc_mode));
endmodule

bind vic_top vic_chk u_chk (
    .clk(clk), .rst(rst), .st(st), .vcfg(vcfg_q), .irq(irq_o),
    .done(ack_done_o), .vec(vec_o), .chain_out_n(chain_out_n)
);

// File: tb/vic_top_tb.sv
module vic_top_tb;
    import vic_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] evt_i = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              iack_n = 1'b1;
    logic              chain_in_n = 1'b1;
    logic              irq_o, ack_done_o, chain_out_n;
    logic [DATA_W-1:0] vec_o;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    vic_top u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iack_n(iack_n),
        .chain_in_n(chain_in_n), .irq_o(irq_o), .vec_o(vec_o),
        .ack_done_o(ack_done_o), .chain_out_n(chain_out_n)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, {8'h00, bus_rdata}, {8'h00, exp});
    endtask

    task automatic pulse(input logic [15:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    // driver: push the expected vector, then run a full acknowledge
    task automatic ack(input logic [7:0] expv);
        exp_q.push_back(expv);
        iack_n = 1'b0; chain_in_n = 1'b0;
        @(negedge clk);
        chk("R7 chain_out held high", {15'b0, chain_out_n}, 16'h1);
        iack_n = 1'b1; chain_in_n = 1'b1;
        @(negedge clk);
    endtask

    // monitor: every completion pulse must match the next expected vector
    always @(negedge clk) begin
        if (!rst && ack_done_o) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R7 unexpected ack: got %h expected none", vec_o);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vec_o !== e) begin
                    bad++;
                    $display("FAIL R6 vector: got %h expected %h", vec_o, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        for (int a = 0; a < 9; a++) rd_chk("R11 reg reset", 4'(a), 8'h00);
        chk("R11 irq", {15'b0, irq_o}, 16'h0);
        chk("R11 chain_out", {15'b0, chain_out_n}, 16'h1);
        chk("R11 done", {15'b0, ack_done_o}, 16'h0);
        chk("R11 vec", {8'h0, vec_o}, 16'h0);
        @(negedge clk);

        // R1 configuration and read-back
        wr(4'd8, 8'hA0); rd_chk("R1 vector", 4'd8, 8'hA0);
        wr(4'd0, 8'hFF); wr(4'd1, 8'hFF);
        rd_chk("R1 enable hi", 4'd0, 8'hFF);
        wr(4'd6, 8'h5A); rd_chk("R1 mask hi", 4'd6, 8'h5A);
        wr(4'd6, 8'hFF); wr(4'd7, 8'hFF);
        rd_chk("R1 mask lo", 4'd7, 8'hFF);

        // R2 event latches
        pulse(16'h0020);
        rd_chk("R2 pend lo", 4'd3, 8'h20);
        chk("R2 irq", {15'b0, irq_o}, 16'h1);

        // R4 disable clears pending
        wr(4'd1, 8'hDF);
        rd_chk("R4 pend cleared", 4'd3, 8'h00);
        chk("R4 irq", {15'b0, irq_o}, 16'h0);
        wr(4'd1, 8'hFF);

        // R3 write-zero-to-clear
        pulse(16'h0020);
        wr(4'd3, 8'hFF); rd_chk("R3 ones ignored", 4'd3, 8'h20);
        wr(4'd3, 8'hDF); rd_chk("R3 zero clears", 4'd3, 8'h00);

        // R2 disabled channel ignores events
        wr(4'd0, 8'h7F);
        pulse(16'h8000);
        rd_chk("R2 disabled ignored", 4'd2, 8'h00);
        wr(4'd0, 8'hFF);

        // R5 mask
        pulse(16'h0004);
        wr(4'd7, 8'hFB);
        chk("R5 masked irq", {15'b0, irq_o}, 16'h0);
        rd_chk("R5 pend latched", 4'd3, 8'h04);
        wr(4'd7, 8'hFF);
        chk("R5 unmasked irq", {15'b0, irq_o}, 16'h1);

        // R6/R7 priority and acknowledge
        pulse(16'h0200);
        ack(8'hA9);
        rd_chk("R7 pend hi cleared", 4'd2, 8'h00);
        ack(8'hA2);
        rd_chk("R7 pend lo cleared", 4'd3, 8'h00);

        // R8 nothing pending: pass down the chain
        iack_n = 1'b0; chain_in_n = 1'b0;
        @(negedge clk);
        chk("R8 chain_out low", {15'b0, chain_out_n}, 16'h0);
        chk("R8 no done", {15'b0, ack_done_o}, 16'h0);
        iack_n = 1'b1; chain_in_n = 1'b1;
        @(negedge clk);
        chk("R8 chain_out restored", {15'b0, chain_out_n}, 16'h1);

        // R7 chain input high: no acknowledge
        pulse(16'h0002);
        iack_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 blocked no done", {15'b0, ack_done_o}, 16'h0);
        chk("R7 blocked chain_out", {15'b0, chain_out_n}, 16'h1);
        rd_chk("R7 blocked pend kept", 4'd3, 8'h02);
        iack_n = 1'b1;
        @(negedge clk);
        ack(8'hA1);

        // R9 in-service mode
        wr(4'd8, 8'hA8);
        pulse(16'h0008);
        ack(8'hA3);
        rd_chk("R9 isr set", 4'd5, 8'h08);
        pulse(16'h000A);
        chk("R9 equal/lower blocked", {15'b0, irq_o}, 16'h0);
        pulse(16'h1000);
        chk("R9 higher requests", {15'b0, irq_o}, 16'h1);
        ack(8'hAC);
        rd_chk("R9 isr hi", 4'd4, 8'h10);
        wr(4'd4, 8'hEF);
        rd_chk("R9 isr hi cleared", 4'd4, 8'h00);
        chk("R9 still blocked", {15'b0, irq_o}, 16'h0);
        wr(4'd5, 8'hF7);
        chk("R9 released", {15'b0, irq_o}, 16'h1);
        ack(8'hA3);
        wr(4'd5, 8'hF7);
        ack(8'hA1);
        rd_chk("R9 isr ch1", 4'd5, 8'h02);
        wr(4'd5, 8'hFF);
        rd_chk("R9 ones ignored", 4'd5, 8'h02);
        wr(4'd1, 8'hFD);
        rd_chk("R4 isr kept on disable", 4'd5, 8'h02);
        wr(4'd1, 8'hFF);
        wr(4'd5, 8'h00);

        // R10 mode off
        wr(4'd8, 8'hA0);
        pulse(16'h0040);
        ack(8'hA6);
        rd_chk("R10 isr never set", 4'd5, 8'h00);

        chk("R7 all acks seen", 16'(exp_q.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule